// File: doc/BRIEF.md
# Four-Times Oversampled Clock and Data Recovery Sampler

This block pulls bits out of a single-wire NRZ stream whose sender runs on its own clock. The local clock runs at about four times the bit rate. The block does not recover the sender's frequency. It only resets its sampling phase each time the line changes level, so that the next sample falls near the middle of the new bit. Between level changes it keeps sampling once every four clocks. The sender must insert stuffed transitions so that no more than seven equal bits ever follow one another.

The line first passes through a synchronizer chain, and a change of level is found by comparing the last two synchronized values. A phase counter picks the sampling cycles. The counter is reloaded on each level change and wraps on its own otherwise. Each recovered bit leaves the block with a one-clock valid strobe. Framing, destuffing and any frequency loop belong to the logic that follows this block.

Top module: `cdr_sampler`

## Requirements
- R1: While reset is high, `bitValid` and `bitOut` are both 0 at the next clock edge and stay 0.
- R2: If `lineIn` changes between clock edges k and k+1, `bitValid` is low after edges k+3 and k+4 and high after edge k+5, with `bitOut` equal to the new level. This holds whatever the sampling phase was before the change.
- R3: While the line holds one level, a strobe comes every four clocks and carries that level.
- R4: Two strobes are never less than three clocks apart. A sender that toggles every bit at three clocks per bit gives strobes exactly three apart. At five clocks per bit the strobes are exactly five apart.
- R5: A run of N equal bits, N from 1 to 7, gives exactly N strobes carrying the run's value when the run lasts from 4N-1 to 4N+2 clocks.
- R6: A stream sent at exactly four clocks per bit is recovered bit for bit, with strobes exactly four clocks apart.
- R7: A fast sender at three clocks per bit, toggling every bit, is recovered without a lost or repeated bit.
- R8: A slow sender at five clocks per bit, toggling every bit, is recovered without a lost or repeated bit.
- R9: Runs of seven equal bits are recovered exactly when the run is stretched to 30 clocks, kept at 28 clocks, or shortened to 27 clocks, and likewise for six-bit runs of 23 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock, nominally four times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| lineIn | input | 1 | Asynchronous serial line |
| bitOut | output | 1 | Last recovered bit |
| bitValid | output | 1 | One-clock strobe marking a new `bitOut` |

## Verification
A single level change is applied at each of the four possible phase offsets. This shows that the first sample lands five edges after the change no matter where the free-running phase stood. A steady line separates free-running from realigned sampling. Alternating streams at three, four and five clocks per bit separate the phase correction from plain counting, because a counter that does not realign slips or repeats a bit within a few bits. Runs of every length from one to seven at both ends of the allowed duration, plus seven-bit runs that are stretched or shrunk, probe the limit between a correct count and a lost or repeated bit.

// File: rtl/cdr_sampler_pkg.sv
`timescale 1ns/1ps
package cdr_sampler_pkg;
  // strobes handed from the phase control to the datapath
  typedef struct packed {
    logic take;   // capture the synchronized line this cycle
  } cdrStrobe_t;
endpackage

// File: rtl/cdr_datapath.sv
`timescale 1ns/1ps
module cdr_datapath
  import cdr_sampler_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lineIn,
  input  cdrStrobe_t strobe,
  output logic       edgeSeen,
  output logic       bitOut,
  output logic       bitValid
);
  logic [SYNC_DEPTH-1:0] syncChain;
  logic                  syncBit;
  logic                  heldBit;

  assign syncBit  = syncChain[SYNC_DEPTH-1];
  assign edgeSeen = syncBit ^ heldBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncChain <= '0;
      heldBit   <= 1'b0;
      bitOut    <= 1'b0;
      bitValid  <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_DEPTH-2:0], lineIn};
      heldBit   <= syncBit;
      bitValid  <= strobe.take;
      if (strobe.take) bitOut <= syncBit;
    end
  end

  // R4: the control never asks for samples on adjacent cycles
  a_r4_no_adjacent: assert property (@(posedge clk) disable iff (rst)
    bitValid |=> !bitValid);
endmodule

// File: rtl/cdr_control.sv
`timescale 1ns/1ps
module cdr_control
  import cdr_sampler_pkg::*;
#(
  parameter int OVERSAMPLE   = 4,
  parameter int CENTER_DELAY = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       edgeSeen,
  output cdrStrobe_t strobe
);
  localparam int CNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int GAP_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(OVERSAMPLE - CENTER_DELAY);

  logic [CNT_W-1:0] phase;
  logic             takeNow;

  always_comb begin
    takeNow     = (phase == LAST) && !edgeSeen;
    strobe.take = takeNow;
  end

  always_ff @(posedge clk) begin
    if (rst)                phase <= '0;
    else if (edgeSeen)      phase <= LOAD;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + CNT_W'(1);
  end

  // cycle counters used only by the checks below
  logic [GAP_W-1:0] gapCnt;
  logic [GAP_W-1:0] sinceEdge;
  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt    <= '1;
      sinceEdge <= '1;
    end else begin
      if (takeNow)              gapCnt <= '0;
      else if (gapCnt != '1)    gapCnt <= gapCnt + GAP_W'(1);
      if (edgeSeen)             sinceEdge <= GAP_W'(1);
      else if (sinceEdge != '1) sinceEdge <= sinceEdge + GAP_W'(1);
    end
  end

  // R2: the sample lands CENTER_DELAY cycles after a detected level change
  a_r2_mid_bit: assert property (@(posedge clk) disable iff (rst)
    (sinceEdge == GAP_W'(CENTER_DELAY)) && !edgeSeen |-> takeNow);
  // R2: nothing is sampled between the change and that point
  a_r2_no_early: assert property (@(posedge clk) disable iff (rst)
    (sinceEdge < GAP_W'(CENTER_DELAY)) |-> !takeNow);
  // R4: minimum spacing between samples
  a_r4_min_gap: assert property (@(posedge clk) disable iff (rst)
    takeNow |-> gapCnt >= GAP_W'(CENTER_DELAY));
  // R3: without level changes, samples repeat every OVERSAMPLE cycles
  a_r3_free_run: assert property (@(posedge clk) disable iff (rst)
    (gapCnt == GAP_W'(OVERSAMPLE - 1)) && (sinceEdge > GAP_W'(OVERSAMPLE)) && !edgeSeen
    |-> takeNow);
endmodule

// File: rtl/cdr_sampler.sv
`timescale 1ns/1ps
module cdr_sampler
  import cdr_sampler_pkg::*;
#(
  parameter int OVERSAMPLE   = 4,
  parameter int SYNC_DEPTH   = 2,
  parameter int CENTER_DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lineIn,
  output logic bitOut,
  output logic bitValid
);
  cdrStrobe_t strobe;
  logic       edgeSeen;

  cdr_control #(
    .OVERSAMPLE  (OVERSAMPLE),
    .CENTER_DELAY(CENTER_DELAY)
  ) u_control (
    .clk     (clk),
    .rst     (rst),
    .edgeSeen(edgeSeen),
    .strobe  (strobe)
  );

  cdr_datapath #(
    .SYNC_DEPTH(SYNC_DEPTH)
  ) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .lineIn  (lineIn),
    .strobe  (strobe),
    .edgeSeen(edgeSeen),
    .bitOut  (bitOut),
    .bitValid(bitValid)
  );
endmodule

// File: tb/cdr_sampler_test.sv
`timescale 1ns/1ps
module cdr_sampler_test;
  logic clk = 1'b0;
  logic rst;
  logic lineIn;
  logic bitOut, bitValid;

  always #10 clk = ~clk;  // 50 MHz

  cdr_sampler uut (
    .clk(clk), .rst(rst), .lineIn(lineIn), .bitOut(bitOut), .bitValid(bitValid)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // recorder of strobes inside a window
  logic recording = 1'b0;
  int   recN = 0;
  logic recBits [256];
  int   lastStrobe = 0;
  int   minGap = 1000;
  int   maxGap = 0;

  always @(negedge clk) begin
    if (recording && bitValid) begin
      if (recN < 256) recBits[recN] = bitOut;
      if (recN > 0) begin
        if (cyc - lastStrobe < minGap) minGap = cyc - lastStrobe;
        if (cyc - lastStrobe > maxGap) maxGap = cyc - lastStrobe;
      end
      lastStrobe = cyc;
      recN++;
    end
  end

  // stimulus description
  logic txVal [64];
  int   txDur [64];
  int   txLen = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pushBit(input logic v, input int d);
    txVal[txLen] = v;
    txDur[txLen] = d;
    txLen++;
  endtask

  task automatic startWindow();
    recording = 1'b1;
    recN = 0;
    minGap = 1000;
    maxGap = 0;
  endtask

  // sends txVal/txDur, then a closing level change; checks the recovered stream
  task automatic sendStream(input string req);
    int errs;
    @(posedge clk);
    #1 lineIn = !txVal[0];
    repeat (8) @(posedge clk);
    #1 lineIn = txVal[0];
    repeat (3) @(posedge clk);
    #1 startWindow();
    repeat (txDur[0] - 3) @(posedge clk);
    for (int i = 1; i < txLen; i++) begin
      #1 lineIn = txVal[i];
      repeat (txDur[i]) @(posedge clk);
    end
    #1 lineIn = !txVal[txLen-1];
    repeat (3) @(posedge clk);
    #1 recording = 1'b0;
    check(recN == txLen, req, "recovered bit count", recN, txLen);
    errs = 0;
    for (int i = 0; i < txLen && i < recN; i++)
      if (recBits[i] !== txVal[i]) errs++;
    check(errs == 0, req, "mismatching recovered bits", errs, 0);
  endtask

  task automatic testReset();
    rst = 1'b1;
    lineIn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bitValid === 1'b0, "R1", "bitValid in reset", int'(bitValid), 0);
    check(bitOut === 1'b0, "R1", "bitOut in reset", int'(bitOut), 0);
    #1 lineIn = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    repeat (10) @(posedge clk);
  endtask

  task automatic testLatency(input int offset);
    logic newLvl;
    repeat (12) @(posedge clk);
    repeat (offset) @(posedge clk);
    #1 lineIn = !lineIn;
    newLvl = lineIn;
    for (int j = 1; j <= 5; j++) begin
      @(posedge clk);
      @(negedge clk);
      if (j == 3 || j == 4)
        check(bitValid === 1'b0, "R2", $sformatf("no strobe edge+%0d offset %0d", j, offset),
              int'(bitValid), 0);
      if (j == 5) begin
        check(bitValid === 1'b1, "R2", $sformatf("strobe at edge+5 offset %0d", offset),
              int'(bitValid), 1);
        check(bitOut === newLvl, "R2", $sformatf("sampled level offset %0d", offset),
              int'(bitOut), int'(newLvl));
      end
    end
  endtask

  task automatic testFreeRun();
    int errs;
    @(posedge clk);
    #1 lineIn = 1'b1;
    repeat (12) @(posedge clk);
    #1 startWindow();
    repeat (40) @(posedge clk);
    #1 recording = 1'b0;
    check(recN == 10, "R3", "strobes in 40 clocks", recN, 10);
    errs = 0;
    for (int i = 0; i < recN && i < 256; i++) if (recBits[i] !== 1'b1) errs++;
    check(errs == 0, "R3", "strobes not carrying line level", errs, 0);
    check(minGap == 4 && maxGap == 4, "R3", "free-run spacing max", maxGap, 4);
  endtask

  task automatic testNominal();
    logic [15:0] pat = 16'b1011_0001_0111_0100;
    txLen = 0;
    for (int i = 15; i >= 0; i--) pushBit(pat[i], 4);
    sendStream("R6");
    check(minGap == 4 && maxGap == 4, "R6", "nominal spacing min", minGap, 4);
  endtask

  task automatic testFast();
    txLen = 0;
    for (int i = 0; i < 12; i++) pushBit(logic'(i % 2 == 0), 3);
    sendStream("R7");
    check(minGap == 3 && maxGap == 3, "R4", "fast sender spacing max", maxGap, 3);
  endtask

  task automatic testSlow();
    txLen = 0;
    for (int i = 0; i < 12; i++) pushBit(logic'(i % 2 == 1), 5);
    sendStream("R8");
    check(minGap == 5 && maxGap == 5, "R4", "slow sender spacing min", minGap, 5);
  endtask

  task automatic testLongRuns();
    txLen = 0;
    pushBit(1'b0, 4);
    // seven ones squeezed into 27 clocks
    for (int j = 0; j < 7; j++) pushBit(1'b1, (j == 3) ? 3 : 4);
    pushBit(1'b0, 4);
    // seven ones stretched to 30 clocks
    for (int j = 0; j < 7; j++) pushBit(1'b1, (j == 0 || j == 3) ? 5 : 4);
    // seven zeros at 28 clocks
    for (int j = 0; j < 7; j++) pushBit(1'b0, 4);
    pushBit(1'b1, 4);
    // six zeros in 23 clocks
    for (int j = 0; j < 6; j++) pushBit(1'b0, (j == 2) ? 3 : 4);
    pushBit(1'b1, 4);
    sendStream("R9");
  endtask

  task automatic testRunBounds();
    logic v = 1'b1;
    txLen = 0;
    for (int n = 1; n <= 7; n++) begin
      // shortest allowed run: 4n-1 clocks
      for (int j = 0; j < n; j++) pushBit(v, (j == 0) ? 3 : 4);
      v = !v;
      // longest allowed run: 4n+2 clocks
      for (int j = 0; j < n; j++) pushBit(v, (n == 1) ? 6 : ((j < 2) ? 5 : 4));
      v = !v;
    end
    sendStream("R5");
    check(minGap >= 3, "R4", "minimum spacing over run bounds", minGap, 3);
  endtask

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    for (int off = 0; off < 4; off++) testLatency(off);
    testFreeRun();
    testNominal();
    testFast();
    testSlow();
    testLongRuns();
    testRunBounds();
    repeat (5) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule